// File: doc/BRIEF.md
# Four-Pin GPIO Pad-Control Register Block

This block drives the pads of a small general-purpose I/O port. Software reaches it through a byte-wide register bus. There is one combinational read port and one write strobe. Four registers hold the per-pin settings: pin direction, output latch, input pull-up enable and open-drain enable. From these settings the block produces, for each pad, an output enable, an output value and a pull-up enable. Pad levels pass through a two-flop synchroniser before software can read them.

A peripheral can take over a pin's output through a select and value pair. The open-drain setting still governs how that peripheral level reaches the pad. In open-drain mode a driven 1 becomes a released pad, and only a 0 is actively driven. A pull-up reaches the pad only while the pin is an input.

There are two reset classes:
- The full reset (`por_n`, asynchronous, active low) covers power-on and hardware standby. It clears every register.
- The light reset (`soft_rst_n`, synchronous, active low) covers a manual reset or software standby. It returns all pins to inputs and keeps the latch, pull-up and open-drain settings.

Top module: `gpio_padctl_top`

## Requirements
- R1: While `por_n` is low and after its release, every register reads 0, `pad_oe` is 0 and `pad_pu` is 0.
- R2: Register addresses are 0 direction (1 = output), 1 data, 2 pull-up and 3 open-drain. Bit i of each register controls pin i. A write stores `bus_wdata[3:0]` on the clock edge, and `bus_rdata` returns the register combinationally from `bus_addr`.
- R3: Bits 7 to 4 of every register ignore writes and always read back as 0.
- R4: `pad_pu[i]` is 1 exactly when the direction bit of pin i is 0 and its pull-up bit is 1.
- R5: With its open-drain bit at 0, an output pin has `pad_oe[i]`=1 and `pad_out[i]` equal to the latch bit, for both levels.
- R6: With its open-drain bit at 1, a pin whose driven level is 0 has `pad_oe[i]`=1 and `pad_out[i]`=0. A pin whose driven level is 1 has `pad_oe[i]`=0.
- R7: When `periph_sel[i]` is 1, pin i drives `periph_out[i]` whatever its direction bit, and the open-drain rule of R6 still applies.
- R8: While `soft_rst_n` is low, the direction register clears to 0 on each clock edge and writes are ignored. The data, pull-up and open-drain registers keep their values.
- R9: A pulse on `por_n` clears the data, pull-up and open-drain registers as well as the direction register.
- R10: A read of address 1 returns, per pin, the latch bit for an output pin. For an input pin it returns the pad level sampled through two clock stages: a change becomes visible after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Full reset, asynchronous, active low |
| soft_rst_n | input | 1 | Light reset, synchronous, active low |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pad_in | input | 4 | Raw pad input levels |
| periph_sel | input | 4 | Peripheral takes over the pin output |
| periph_out | input | 4 | Peripheral output level |
| pad_oe | output | 4 | Pad output enable |
| pad_out | output | 4 | Pad output value |
| pad_pu | output | 4 | Pad pull-up enable |

## Verification
The bench builds the block with its defaults: four pins, an 8-bit register width and two synchroniser stages. With four pins a single write can set a mix of open-drain and push-pull pins and a mix of high and low levels, so each drive case appears in one vector. The 8-bit width leaves four reserved bits to write with ones. Two stages give an exact edge count for the input-read latency, which the bench probes one edge early and one edge on time.

// File: rtl/gpio_pc_pkg.sv
package gpio_pc_pkg;

  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PULL = 2'd2,
    SEL_ODRN = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pin_drive_t;

  // Level a pin wants to drive and whether it wants to drive at all,
  // reshaped by the open-drain rule: a wanted 1 in open-drain is released.
  function automatic pin_drive_t pin_drive(input logic dir, input logic latch,
                                           input logic psel, input logic pout,
                                           input logic odrn);
    pin_drive_t d;
    logic want;
    logic lvl;
    want  = psel | dir;
    lvl   = psel ? pout : latch;
    d.oe  = want & ~(odrn & lvl);
    d.val = lvl & ~odrn;
    return d;
  endfunction

  // Pull-up only reaches an input pin.
  function automatic logic pin_pull(input logic dir, input logic pull);
    return ~dir & pull;
  endfunction

  // Data read: latch for outputs, synchronised pad for inputs.
  function automatic logic pin_readback(input logic dir, input logic latch,
                                        input logic pad_sync);
    return dir ? latch : pad_sync;
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pc_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                soft_rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [NUM_PINS-1:0] wr_bits,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] dat_q,
  output logic [NUM_PINS-1:0] pull_q,
  output logic [NUM_PINS-1:0] odrn_q
);

  // Named write events, brought out for the checks below.
  logic wr_ok;
  logic wr_dir, wr_dat, wr_pull, wr_odrn;

  assign wr_ok   = wr_en & soft_rst_n;
  assign wr_dir  = wr_ok & (wr_addr == SEL_DIR);
  assign wr_dat  = wr_ok & (wr_addr == SEL_DATA);
  assign wr_pull = wr_ok & (wr_addr == SEL_PULL);
  assign wr_odrn = wr_ok & (wr_addr == SEL_ODRN);

  // Direction: cleared by both reset classes.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           dir_q <= '0;
    else if (!soft_rst_n) dir_q <= '0;
    else if (wr_dir)      dir_q <= wr_bits;
  end

  // Latch, pull-up and open-drain: cleared only by the full reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dat_q  <= '0;
      pull_q <= '0;
      odrn_q <= '0;
    end else begin
      if (wr_dat)  dat_q  <= wr_bits;
      if (wr_pull) pull_q <= wr_bits;
      if (wr_odrn) odrn_q <= wr_bits;
    end
  end

  // R8
  soft_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    !soft_rst_n |=> (dir_q == '0) && $stable(dat_q) && $stable(pull_q) && $stable(odrn_q));

  // R2
  pull_store_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_pull |=> pull_q == $past(wr_bits));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!wr_en && soft_rst_n) |=> $stable(dir_q) && $stable(dat_q) && $stable(odrn_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 4,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic [NUM_PINS-1:0] raw_in,
  output logic [NUM_PINS-1:0] sync_out
);

  localparam int CW = $clog2(STAGES + 1);

  logic [NUM_PINS-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[0] <= '0;
          else        chain[0] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge por_n) begin
          if (!por_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

  // Edges seen since reset, saturating; guards the latency check.
  logic [CW-1:0] warm;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 warm <= '0;
    else if (warm != CW'(STAGES)) warm <= warm + 1'b1;
  end

  generate
    if (STAGES == 2) begin : g_lat_chk
      // R10
      sync_latency_chk: assert property (@(posedge clk) disable iff (!por_n)
        (warm == CW'(STAGES)) |-> sync_out == $past(raw_in, 2));
    end
  endgenerate

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_pc_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] dat_q,
  input  logic [NUM_PINS-1:0] pull_q,
  input  logic [NUM_PINS-1:0] odrn_q,
  input  logic [NUM_PINS-1:0] psel,
  input  logic [NUM_PINS-1:0] pout,
  output logic [NUM_PINS-1:0] oe,
  output logic [NUM_PINS-1:0] val,
  output logic [NUM_PINS-1:0] pu
);

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pin_drive_t drv;
      assign drv   = pin_drive(dir_q[i], dat_q[i], psel[i], pout[i], odrn_q[i]);
      assign oe[i] = drv.oe;
      assign val[i] = drv.val;
      assign pu[i] = pin_pull(dir_q[i], pull_q[i]);

      // R6
      odrn_no_high_chk: assert property (@(posedge clk) disable iff (!por_n)
        (oe[i] && odrn_q[i]) |-> !val[i]);

      // R4
      pull_input_only_chk: assert property (@(posedge clk) disable iff (!por_n)
        pu[i] |-> (!dir_q[i] && pull_q[i]));

      // R5
      idle_input_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!dir_q[i] && !psel[i]) |-> !oe[i]);
    end
  endgenerate

endmodule

// File: rtl/gpio_padctl_top.sv
module gpio_padctl_top
  import gpio_pc_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                soft_rst_n,
  input  logic [1:0]          bus_addr,
  input  logic                bus_we,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic [NUM_PINS-1:0] periph_sel,
  input  logic [NUM_PINS-1:0] periph_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_pu
);

  localparam int PAD_W = REG_W - NUM_PINS;

  logic [NUM_PINS-1:0] dir_q, dat_q, pull_q, odrn_q, pad_sync, data_view;
  logic                unused_wr_hi;

  assign unused_wr_hi = ^bus_wdata[REG_W-1:NUM_PINS];

  gpio_cfg_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .soft_rst_n (soft_rst_n),
    .wr_en      (bus_we),
    .wr_addr    (bus_addr),
    .wr_bits    (bus_wdata[NUM_PINS-1:0]),
    .dir_q      (dir_q),
    .dat_q      (dat_q),
    .pull_q     (pull_q),
    .odrn_q     (odrn_q)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .por_n    (por_n),
    .raw_in   (pad_in),
    .sync_out (pad_sync)
  );

  gpio_pad_drive #(.NUM_PINS(NUM_PINS)) u_drive (
    .clk    (clk),
    .por_n  (por_n),
    .dir_q  (dir_q),
    .dat_q  (dat_q),
    .pull_q (pull_q),
    .odrn_q (odrn_q),
    .psel   (periph_sel),
    .pout   (periph_out),
    .oe     (pad_oe),
    .val    (pad_out),
    .pu     (pad_pu)
  );

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_view
      assign data_view[i] = pin_readback(dir_q[i], dat_q[i], pad_sync[i]);
    end
  endgenerate

  always_comb begin
    unique case (bus_addr)
      SEL_DIR:  bus_rdata = {{PAD_W{1'b0}}, dir_q};
      SEL_DATA: bus_rdata = {{PAD_W{1'b0}}, data_view};
      SEL_PULL: bus_rdata = {{PAD_W{1'b0}}, pull_q};
      SEL_ODRN: bus_rdata = {{PAD_W{1'b0}}, odrn_q};
      default:  bus_rdata = '0;
    endcase
  end

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    bus_rdata[REG_W-1:NUM_PINS] == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !por_n |-> (pad_oe == '0) && (pad_pu == '0) || (periph_sel != '0));

endmodule

// File: tb/sim_gpio_padctl_top.sv
module sim_gpio_padctl_top;

  logic       clk = 1'b0;
  logic       por_n, soft_rst_n, bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] pad_in, periph_sel, periph_out, pad_oe, pad_out, pad_pu;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_padctl_top u0 (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .periph_sel(periph_sel),
    .periph_out(periph_out), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a;
    #0.5;
    check(req, $sformatf("read addr %0d", a), bus_rdata, exp);
  endtask

  task automatic pads_chk(input string req, input logic [3:0] oe, input logic [3:0] ov);
    #0.5;
    check(req, "pad_oe", {4'h0, pad_oe}, {4'h0, oe});
    check(req, "pad_out (driven pins)", {4'h0, pad_out & pad_oe}, {4'h0, ov});
  endtask

  task automatic t_reset;
    #0.5;
    check("R1", "pad_oe in reset", {4'h0, pad_oe}, 8'h00);
    check("R1", "pad_pu in reset", {4'h0, pad_pu}, 8'h00);
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) rd_chk("R1", 2'(a), 8'h00);
  endtask

  task automatic t_regmap;
    wr(2'd0, 8'h05); rd_chk("R2", 2'd0, 8'h05);
    wr(2'd2, 8'h0A); rd_chk("R2", 2'd2, 8'h0A);
    wr(2'd3, 8'h03); rd_chk("R2", 2'd3, 8'h03);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_reserved;
    wr(2'd2, 8'hF6); rd_chk("R3", 2'd2, 8'h06);
    wr(2'd3, 8'hA9); rd_chk("R3", 2'd3, 8'h09);
    wr(2'd0, 8'hF0); rd_chk("R3", 2'd0, 8'h00);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_pullup;
    wr(2'd0, 8'h03); wr(2'd2, 8'h0F);
    #0.5; check("R4", "pull mixed dir", {4'h0, pad_pu}, 8'h0C);
    wr(2'd0, 8'h00);
    #0.5; check("R4", "pull all inputs", {4'h0, pad_pu}, 8'h0F);
    wr(2'd2, 8'h00);
    #0.5; check("R4", "pull disabled", {4'h0, pad_pu}, 8'h00);
  endtask

  task automatic t_pushpull;
    wr(2'd3, 8'h00); wr(2'd0, 8'h0F); wr(2'd1, 8'h05);
    pads_chk("R5", 4'hF, 4'h5);
    wr(2'd1, 8'h0A);
    pads_chk("R5", 4'hF, 4'hA);
  endtask

  task automatic t_opendrain;
    wr(2'd3, 8'h0F); wr(2'd1, 8'h05);
    pads_chk("R6", 4'hA, 4'h0);
    wr(2'd3, 8'h03);
    pads_chk("R6", 4'hE, 4'h4);
    wr(2'd3, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
  endtask

  task automatic t_periph;
    wr(2'd3, 8'h01);
    @(negedge clk); periph_sel = 4'h3; periph_out = 4'h3;
    pads_chk("R7", 4'h2, 4'h2);
    @(negedge clk); periph_out = 4'h0;
    pads_chk("R7", 4'h3, 4'h0);
    @(negedge clk); periph_sel = 4'h0;
    wr(2'd3, 8'h00);
  endtask

  task automatic t_sync;
    @(negedge clk); pad_in = 4'h9; bus_addr = 2'd1;
    @(posedge clk); #0.5;
    check("R10", "pad after one edge", bus_rdata, 8'h00);
    @(posedge clk); #0.5;
    check("R10", "pad after two edges", bus_rdata, 8'h09);
    wr(2'd1, 8'h06); wr(2'd0, 8'h0F);
    rd_chk("R10", 2'd1, 8'h06);
    wr(2'd0, 8'h03);
    rd_chk("R10", 2'd1, 8'h0A);
    wr(2'd0, 8'h00);
    @(negedge clk); pad_in = 4'h0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_soft;
    wr(2'd0, 8'h0F); wr(2'd1, 8'h05); wr(2'd2, 8'h06); wr(2'd3, 8'h09);
    @(negedge clk); soft_rst_n = 1'b0;
    bus_addr = 2'd1; bus_wdata = 8'h0F; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    @(negedge clk);
    check("R8", "pad_oe during light reset", {4'h0, pad_oe}, 8'h00);
    soft_rst_n = 1'b1;
    rd_chk("R8", 2'd0, 8'h00);
    rd_chk("R8", 2'd2, 8'h06);
    rd_chk("R8", 2'd3, 8'h09);
    wr(2'd0, 8'h0F);
    rd_chk("R8", 2'd1, 8'h05);
  endtask

  task automatic t_por;
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    rd_chk("R9", 2'd0, 8'h00);
    rd_chk("R9", 2'd2, 8'h00);
    rd_chk("R9", 2'd3, 8'h00);
    wr(2'd0, 8'h0F);
    rd_chk("R9", 2'd1, 8'h00);
  endtask

  initial begin
    por_n = 1'b0; soft_rst_n = 1'b1; bus_we = 1'b0; bus_addr = 2'd0;
    bus_wdata = 8'h00; pad_in = 4'h0; periph_sel = 4'h0; periph_out = 4'h0;
    repeat (3) @(negedge clk);
    t_reset;
    t_regmap;
    t_reserved;
    t_pullup;
    t_pushpull;
    t_opendrain;
    t_periph;
    t_sync;
    t_soft;
    t_por;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule